// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the sixteen logical general registers of a 32-bit processor core. It maps them onto a larger physical store so that each exception mode sees its own stack pointer and link register. The fast-interrupt mode also gets its own copies of the upper working registers, so a handler can run without first spilling the state it interrupted. The physical register that a logical index reaches depends on the 5-bit processor mode presented on `mode`. All three access ports share that mode input.

There are two combinational read ports and one synchronous write port. A write that targets the same physical register that a read port is selecting in the same cycle is forwarded to that read port. Each port has a user-bank strobe that forces the user-mode mapping for that access alone. Privileged save and restore code uses it to reach the interrupted task's r13 and r14 while staying in its own mode. A mode value that matches none of the seven legal encodings is banked as user mode and is flagged on `mode_err`.

Physical layout:
- slots 0–15 hold the user set, and slot 15 is r15.
- slots 16–22 hold fast-interrupt r8–r14.
- slots 23–30 hold the r13/r14 pairs of the interrupt, supervisor, abort and undefined modes, in that order.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets all 31 physical registers to zero. Afterwards every logical register reads 0 in every mode.
- R2: User mode (10000) and system mode (11111) both map logical r0–r15 onto the same user set. A value written in one of these modes reads back in the other.
- R3: In fast-interrupt mode (10001), logical r8–r14 reach seven registers private to that mode. Writes to them leave the user r8–r14 unchanged, while r0–r7 stay shared with user mode.
- R4: Interrupt (10010), supervisor (10011), abort (10111) and undefined (11011) modes each own a private r13 and r14. r0–r12 stay shared with user mode in these modes.
- R5: Logical r15 is a single register that reads the same in every mode.
- R6: Any mode value other than the seven legal encodings is banked as user mode, and `mode_err` is 1 for as long as that value is present. For legal modes `mode_err` is 0.
- R7: Reads are combinational from the index, mode and strobe inputs. A write takes effect at the rising clock edge where `we` is 1. A read of a different physical register in that cycle returns the old contents.
- R8: When `we` is 1 and a read port selects the physical register being written, that port returns `wr_data` in the same cycle.
- R9: `ra_usr`, `rb_usr` and `wr_usr` each force the user mapping for their own port only, whatever the current mode.
- R10: When `we` is 0, no physical register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 5 | Current processor mode encoding |
| ra_idx | input | 4 | Read port A logical index |
| ra_usr | input | 1 | Force user mapping on port A |
| ra_data | output | 32 | Read port A data |
| rb_idx | input | 4 | Read port B logical index |
| rb_usr | input | 1 | Force user mapping on port B |
| rb_data | output | 32 | Read port B data |
| we | input | 1 | Write enable |
| wr_idx | input | 4 | Write logical index |
| wr_usr | input | 1 | Force user mapping on the write |
| wr_data | input | 32 | Write data |
| mode_err | output | 1 | Mode input is not a legal encoding |

## Verification
The assertions assume that `mode`, the indices and the strobes are steady and fully known at every rising edge outside reset. They also assume that reset is held for at least one edge before any write is checked. The bench changes all inputs only on falling edges and starts with reset asserted from time zero. Illegal mode values are held for a whole cycle, as legal ones are, so the decoder never sees an unknown value.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;
  localparam int NUM_LOG  = 16;
  localparam int IDX_W    = 4;
  localparam int NUM_PHYS = 31;
  localparam int PHYS_W   = 5;
  localparam int FIQ_BASE = 16;
  localparam int XPAIR_BASE = 23;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

  // Logical index plus bank to physical slot.
  function automatic logic [PHYS_W-1:0] phys_of(bank_e b, logic [IDX_W-1:0] idx);
    logic [PHYS_W-1:0] slot;
    slot = {1'b0, idx};
    if (idx != 4'd15) begin
      if (b == BK_FIQ && idx >= 4'd8) begin
        slot = PHYS_W'(FIQ_BASE) + {1'b0, idx} - 5'd8;
      end else if (b != BK_USR && b != BK_FIQ && idx >= 4'd13) begin
        slot = PHYS_W'(XPAIR_BASE)
             + PHYS_W'((int'(b) - int'(BK_IRQ)) * 2)
             + {1'b0, idx} - 5'd13;
      end
    end
    return slot;
  endfunction
endpackage

// File: rtl/mode_decode.sv
module mode_decode
  import bankreg_pkg::*;
(
  input  logic [4:0] mode,
  output bank_e      bank,
  output logic       illegal
);
  always_comb begin
    illegal = 1'b0;
    unique case (mode)
      5'b10000: bank = BK_USR;
      5'b11111: bank = BK_USR;
      5'b10001: bank = BK_FIQ;
      5'b10010: bank = BK_IRQ;
      5'b10011: bank = BK_SVC;
      5'b10111: bank = BK_ABT;
      5'b11011: bank = BK_UND;
      default: begin
        bank    = BK_USR;
        illegal = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/phys_map.sv
module phys_map
  import bankreg_pkg::*;
(
  input  bank_e             bank,
  input  logic              usr,
  input  logic [IDX_W-1:0]  idx,
  output logic [PHYS_W-1:0] phys
);
  bank_e eff_bank;
  assign eff_bank = usr ? BK_USR : bank;
  assign phys     = phys_of(eff_bank, idx);
endmodule

// File: rtl/reg_store.sv
module reg_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 31,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [AW-1:0]     raa,
  output logic [DATA_W-1:0] rda,
  input  logic [AW-1:0]     rab,
  output logic [DATA_W-1:0] rdb
);
  logic [DATA_W-1:0] regs [DEPTH];
  logic              fwd_a, fwd_b;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                          regs[g] <= '0;
      else if (we && wa == AW'(g))      regs[g] <= wd;
    end
  end

  assign fwd_a = we && (wa == raa);
  assign fwd_b = we && (wa == rab);
  assign rda   = fwd_a ? wd : regs[raa];
  assign rdb   = fwd_b ? wd : regs[rab];

  // R7: a write lands in the addressed slot at the edge
  a_r7_write_lands: assert property (@(posedge clk) disable iff (rst)
    we |=> regs[$past(wa)] == $past(wd));
  // R1: reset clears storage
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (regs[0] == '0 && regs[DEPTH-1] == '0));
  // R10: without a write, slot 0 keeps its value
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (!we || wa != '0) |=> $stable(regs[0]));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bankreg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [4:0]        mode,
  input  logic [3:0]        ra_idx,
  input  logic              ra_usr,
  output logic [DATA_W-1:0] ra_data,
  input  logic [3:0]        rb_idx,
  input  logic              rb_usr,
  output logic [DATA_W-1:0] rb_data,
  input  logic              we,
  input  logic [3:0]        wr_idx,
  input  logic              wr_usr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              mode_err
);
  bank_e             cur_bank;
  logic [PHYS_W-1:0] ra_phys, rb_phys, wr_phys;

  mode_decode u_dec (.mode(mode), .bank(cur_bank), .illegal(mode_err));

  phys_map u_map_a (.bank(cur_bank), .usr(ra_usr), .idx(ra_idx), .phys(ra_phys));
  phys_map u_map_b (.bank(cur_bank), .usr(rb_usr), .idx(rb_idx), .phys(rb_phys));
  phys_map u_map_w (.bank(cur_bank), .usr(wr_usr), .idx(wr_idx), .phys(wr_phys));

  reg_store #(.DATA_W(DATA_W), .DEPTH(NUM_PHYS)) u_store (
    .clk(clk), .rst(rst), .we(we), .wa(wr_phys), .wd(wr_data),
    .raa(ra_phys), .rda(ra_data), .rab(rb_phys), .rdb(rb_data));

  // R6: an illegal mode banks as user
  a_r6_illegal_user: assert property (@(posedge clk) disable iff (rst)
    mode_err |-> cur_bank == BK_USR);
  // R5: r15 always reaches the shared slot
  a_r5_pc_shared: assert property (@(posedge clk) disable iff (rst)
    (ra_idx == 4'd15) |-> ra_phys == 5'd15);
  // R9: user strobe yields the identity mapping
  a_r9_user_force: assert property (@(posedge clk) disable iff (rst)
    ra_usr |-> ra_phys == {1'b0, ra_idx});
  // R8: same-slot write is forwarded to the read port
  a_r8_forward: assert property (@(posedge clk) disable iff (rst)
    (we && wr_phys == ra_phys) |-> ra_data == wr_data);
  // R3: fast-interrupt upper registers reach private slots
  a_r3_fiq_private: assert property (@(posedge clk) disable iff (rst)
    (cur_bank == BK_FIQ && !ra_usr && ra_idx >= 4'd8 && ra_idx <= 4'd14)
      |-> (ra_phys >= 5'd16 && ra_phys <= 5'd22));
endmodule

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;
  localparam logic [4:0] M_USR = 5'b10000, M_FIQ = 5'b10001, M_IRQ = 5'b10010,
                         M_SVC = 5'b10011, M_ABT = 5'b10111, M_UND = 5'b11011,
                         M_SYS = 5'b11111;

  logic clk = 0, rst = 1;
  logic [4:0] mode = M_USR;
  logic [3:0] ra_idx = 0, rb_idx = 0, wr_idx = 0;
  logic ra_usr = 0, rb_usr = 0, wr_usr = 0, we = 0;
  logic [31:0] wr_data = 0, ra_data, rb_data;
  logic mode_err;
  int n_tests = 0, n_fail = 0;
  logic [31:0] model [31];

  always #10 clk = ~clk;

  banked_regfile u_dut (.clk, .rst, .mode, .ra_idx, .ra_usr, .ra_data,
    .rb_idx, .rb_usr, .rb_data, .we, .wr_idx, .wr_usr, .wr_data, .mode_err);

  // Bench's own view of where a logical register lives.
  function automatic int slot(logic [4:0] m, logic [3:0] i, logic u);
    int pair;
    if (u || i == 15 || i < 8) return i;
    pair = -1;
    if (m == M_IRQ) pair = 23;
    if (m == M_SVC) pair = 25;
    if (m == M_ABT) pair = 27;
    if (m == M_UND) pair = 29;
    if (m == M_FIQ) return 16 + (i - 8);
    if (pair >= 0 && i >= 13) return pair + (i - 13);
    return i;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] m, logic [3:0] i, logic [31:0] d, logic u = 0);
    @(negedge clk);
    mode = m; wr_idx = i; wr_data = d; wr_usr = u; we = 1;
    @(negedge clk);
    we = 0; wr_usr = 0;
    model[slot(m, i, u)] = d;
  endtask

  task automatic rd(string req, logic [4:0] m, logic [3:0] i, logic u = 0);
    mode = m; ra_idx = i; ra_usr = u;
    rb_idx = i; rb_usr = u;
    #1;
    check(req, ra_data, model[slot(m, i, u)]);
    check(req, rb_data, model[slot(m, i, u)]);
    ra_usr = 0; rb_usr = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    for (int k = 0; k < 31; k++) model[k] = '0;
  endtask

  task automatic t_reset();
    wr(M_FIQ, 4'd9, 32'hDEAD_0009);
    wr(M_SVC, 4'd13, 32'hDEAD_0013);
    do_reset();
    for (int k = 0; k < 16; k++) rd("R1", M_USR, 4'(k));
    rd("R1", M_FIQ, 4'd9);
    rd("R1", M_SVC, 4'd13);
  endtask

  task automatic t_user_sys();
    wr(M_USR, 4'd5, 32'h0000_5555);
    wr(M_SYS, 4'd13, 32'h1313_0000);
    rd("R2", M_SYS, 4'd5);
    rd("R2", M_USR, 4'd13);
    check("R2", ra_data, 32'h1313_0000);
  endtask

  task automatic t_fiq();
    wr(M_USR, 4'd8, 32'hAAAA_0008);
    wr(M_FIQ, 4'd8, 32'hF1F1_0008);
    wr(M_FIQ, 4'd14, 32'hF1F1_0014);
    wr(M_FIQ, 4'd3, 32'h3333_F1F1);
    rd("R3", M_USR, 4'd8);
    check("R3", ra_data, 32'hAAAA_0008);
    rd("R3", M_FIQ, 4'd8);
    check("R3", ra_data, 32'hF1F1_0008);
    rd("R3", M_USR, 4'd3);
    check("R3", ra_data, 32'h3333_F1F1);
    rd("R3", M_USR, 4'd14);
  endtask

  task automatic t_except();
    logic [4:0] ms [4] = '{M_IRQ, M_SVC, M_ABT, M_UND};
    wr(M_USR, 4'd13, 32'h0000_0D0D);
    for (int k = 0; k < 4; k++) begin
      wr(ms[k], 4'd13, 32'h5000_0000 + k);
      wr(ms[k], 4'd14, 32'h6000_0000 + k);
    end
    wr(M_ABT, 4'd12, 32'h1212_ABAB);
    for (int k = 0; k < 4; k++) begin
      rd("R4", ms[k], 4'd13);
      check("R4", ra_data, 32'h5000_0000 + k);
      rd("R4", ms[k], 4'd14);
      rd("R4", ms[k], 4'd12);
      check("R4", ra_data, 32'h1212_ABAB);
    end
    rd("R4", M_USR, 4'd13);
    check("R4", ra_data, 32'h0000_0D0D);
  endtask

  task automatic t_pc();
    wr(M_SVC, 4'd15, 32'h0000_8000);
    rd("R5", M_FIQ, 4'd15); check("R5", ra_data, 32'h0000_8000);
    rd("R5", M_USR, 4'd15); check("R5", ra_data, 32'h0000_8000);
    rd("R5", M_UND, 4'd15);
  endtask

  task automatic t_illegal();
    mode = 5'b10100; #1;
    check("R6", 32'(mode_err), 32'd1);
    wr(5'b10100, 4'd13, 32'hBAD0_0013);
    rd("R6", M_USR, 4'd13);
    check("R6", ra_data, 32'hBAD0_0013);
    rd("R6", M_IRQ, 4'd13);
    mode = 5'b00000; #1; check("R6", 32'(mode_err), 32'd1);
    mode = M_SYS; #1;    check("R6", 32'(mode_err), 32'd0);
    mode = M_FIQ; #1;    check("R6", 32'(mode_err), 32'd0);
  endtask

  task automatic t_comb_read();
    wr(M_USR, 4'd2, 32'h2222_0000);
    wr(M_USR, 4'd3, 32'h3333_0000);
    @(negedge clk);
    mode = M_USR; we = 1; wr_idx = 4'd2; wr_data = 32'h2222_FFFF;
    ra_idx = 4'd3; #1;
    check("R7", ra_data, 32'h3333_0000);
    ra_idx = 4'd2; rb_idx = 4'd3; #1;
    check("R8", ra_data, 32'h2222_FFFF);
    check("R7", rb_data, 32'h3333_0000);
    @(negedge clk); we = 0; model[2] = 32'h2222_FFFF;
    rd("R7", M_USR, 4'd2);
  endtask

  task automatic t_forward();
    wr(M_SVC, 4'd14, 32'h0E0E_5555);
    @(negedge clk);
    mode = M_SVC; we = 1; wr_idx = 4'd13; wr_data = 32'hF0F0_1313;
    ra_idx = 4'd13; rb_idx = 4'd14; #1;
    check("R8", ra_data, 32'hF0F0_1313);
    check("R8", rb_data, 32'h0E0E_5555);
    rb_idx = 4'd13; rb_usr = 1; #1;
    check("R8", rb_data, model[13]);
    @(negedge clk); we = 0; rb_usr = 0; model[25] = 32'hF0F0_1313;
    rd("R8", M_SVC, 4'd13);
  endtask

  task automatic t_user_strobe();
    wr(M_IRQ, 4'd13, 32'hC0DE_0013, 1'b1);
    rd("R9", M_USR, 4'd13); check("R9", ra_data, 32'hC0DE_0013);
    wr(M_USR, 4'd14, 32'h1111_0014);
    wr(M_IRQ, 4'd14, 32'h2222_0014);
    @(negedge clk);
    mode = M_IRQ; ra_idx = 4'd14; ra_usr = 1; rb_idx = 4'd14; rb_usr = 0; #1;
    check("R9", ra_data, 32'h1111_0014);
    check("R9", rb_data, 32'h2222_0014);
    ra_usr = 0;
  endtask

  task automatic t_we_low();
    @(negedge clk);
    mode = M_FIQ; we = 0; wr_idx = 4'd10; wr_data = 32'hFFFF_FFFF;
    @(negedge clk);
    mode = M_USR; wr_idx = 4'd0;
    @(negedge clk);
    rd("R10", M_FIQ, 4'd10);
    rd("R10", M_USR, 4'd0);
  endtask

  initial begin
    for (int k = 0; k < 31; k++) model[k] = '0;
    @(negedge clk); @(negedge clk); rst = 0;
    rd("R1", M_USR, 4'd0);
    t_reset();
    t_user_sys();
    t_fiq();
    t_except();
    t_pc();
    t_illegal();
    t_comb_read();
    t_forward();
    t_user_strobe();
    t_we_low();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule